// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers the four level-sensitive PCI interrupt request lines (INTA# to INTD#, presented here as active-high requests) onto ISA-style interrupt numbers. Software programs eight routing bytes through a small configuration write port at offsets 0x88 to 0x8F. Each byte carries two 4-bit routing codes. The address parity of the byte decides which pair of pins the two codes steer.

A nonzero code picks one of seven fixed interrupt numbers. A code whose low three bits are zero leaves its pin unrouted. The block drives a 16-bit interrupt vector. Each bit of that vector is high whenever at least one asserted pin is routed to that number. It also presents the current interrupt number of each pin, so the routing can be inspected. Every routing byte reads back exactly as it was written.

Top module: `irq_line_router`

## Requirements
- R1: After a synchronous active-low reset, every routing byte reads 0x00, every pin's routed number in `route_irq` is 0 (unrouted) and `irq_out` is all zero.
- R2: A write to any offset 0x88 to 0x8F stores all eight bits, and `cfg_rdata` returns that byte while `cfg_addr` selects it, starting in the cycle after the write edge.
- R3: A write at an odd offset in the window sets the route of INTB (pin 1, `route_irq[7:4]`) from data bits 3:0 and the route of INTA (pin 0, `route_irq[3:0]`) from data bits 7:4. It leaves INTC and INTD unchanged.
- R4: A write at an even offset in the window sets the route of INTD (pin 3, `route_irq[15:12]`) from data bits 3:0 and the route of INTC (pin 2, `route_irq[11:8]`) from data bits 7:4. It leaves INTA and INTB unchanged.
- R5: A routing code of 0 makes its pin unrouted: its `route_irq` field reads 0 and the pin drives no `irq_out` bit.
- R6: A nonzero code maps through its low three bits k (1 to 7) to interrupt number 5, 9, 10, 11, 12, 14 or 15 respectively. Bit 3 of the code is ignored.
- R7: A code of 8 (low three bits zero, bit 3 set) is treated as unrouted, exactly like 0.
- R8: `irq_out[n]` is 1 exactly when at least one asserted `int_req` pin is routed to number n. Several pins on one number combine by OR. Unrouted pins affect no bit. The output follows `int_req` in the same cycle.
- R9: A write with `cfg_addr` outside 0x88 to 0x8F changes no route and no stored byte. Reads outside the window return 0x00.
- R10: Later writes override earlier ones: the most recent write of either parity fully determines the routes of its two pins, whichever of the four same-parity offsets it used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset, for both write and read |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Byte stored at `cfg_addr`; 0 outside the window |
| int_req | input | 4 | Level interrupt requests, bit 0 = INTA up to bit 3 = INTD, high = asserted |
| irq_out | output | 16 | One bit per interrupt number, OR of routed asserted pins |
| route_irq | output | 16 | Routed number per pin, 4 bits each (pin p at bits 4p+3:4p), 0 = unrouted |

## Verification
The hardest situation to reach from the ports is two or more pins sharing one interrupt number while other pins are unrouted through the unusual code 8. That arrangement needs writes of both parities to agree. The stimulus table reaches it by a sequence of writes. Each write changes one pin pair while the other pair keeps its earlier route. It ends with both even-side pins on number 5 and one odd-side pin also on 5, with requests toggled so that the OR matters. Parity override across different offsets of the same parity, and writes just outside the window, are part of the same sequence.

// File: rtl/irq_rtr_pkg.sv
// Shared constants and the code-to-number mapping for the interrupt router.
// Assumes four pins and a 16-line interrupt vector.
package irq_rtr_pkg;
    localparam int PIN_CNT   = 4;
    localparam int NUM_W     = 4;
    localparam int LINE_CNT  = 16;
    localparam int CODE_W    = 4;

    // Map the low three bits of a routing code to an interrupt number; 0 means unrouted.
    function automatic logic [NUM_W-1:0] code_to_num(input logic [2:0] sel);
        case (sel)
            3'd1:    code_to_num = 4'd5;
            3'd2:    code_to_num = 4'd9;
            3'd3:    code_to_num = 4'd10;
            3'd4:    code_to_num = 4'd11;
            3'd5:    code_to_num = 4'd12;
            3'd6:    code_to_num = 4'd14;
            3'd7:    code_to_num = 4'd15;
            default: code_to_num = 4'd0;
        endcase
    endfunction
endpackage

// File: rtl/rtr_cfg_store.sv
// Byte store for the routing window. Flags writes that hit the window and
// reports their parity. Assumes BASE_ADDR is aligned to N_BYTES.
module rtr_cfg_store #(
    parameter int          ADDR_W    = 8,
    parameter int          N_BYTES   = 8,
    parameter logic [7:0]  BASE_ADDR = 8'h88
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              wr_hit,
    output logic              wr_odd
);
    localparam int IDX_W = $clog2(N_BYTES);

    logic [7:0]       mem [N_BYTES];
    logic [IDX_W-1:0] idx;
    logic             in_win;

    // Decode the window and the byte index from the offset.
    always_comb begin
        idx    = addr[IDX_W-1:0];
        in_win = (addr[ADDR_W-1:IDX_W] == BASE_ADDR[ADDR_W-1:IDX_W]);
        wr_hit = we && in_win;
        wr_odd = addr[0];
    end

    // Hold the routing bytes; clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_BYTES; i++) mem[i] <= 8'h00;
        end else if (wr_hit) begin
            mem[idx] <= wdata;
        end
    end

    // Return the selected byte, or zero outside the window.
    always_comb rdata = in_win ? mem[idx] : 8'h00;

    // R2
    byte_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (mem[$past(idx)] == $past(wdata)));
endmodule

// File: rtl/rtr_pin_map.sv
// Holds the routing code of each pin. An odd-offset write updates pins 0/1,
// and an even-offset write updates pins 2/3. Turns each code into an interrupt number.
module rtr_pin_map
    import irq_rtr_pkg::*;
#(
    parameter int PINS = PIN_CNT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_hit,
    input  logic                  wr_odd,
    input  logic [7:0]            wdata,
    output logic [PINS*NUM_W-1:0] route_num
);
    logic [CODE_W-1:0] code [PINS];

    // Capture the two codes of each window write into the pin pair chosen by parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < PINS; p++) code[p] <= '0;
        end else if (wr_hit) begin
            if (wr_odd) begin
                code[0] <= wdata[7:4];
                code[1] <= wdata[3:0];
            end else begin
                code[2] <= wdata[7:4];
                code[3] <= wdata[3:0];
            end
        end
    end

    genvar gp;
    generate
        for (gp = 0; gp < PINS; gp++) begin : g_pin
            // Translate this pin's code to its interrupt number.
            always_comb route_num[gp*NUM_W +: NUM_W] = code_to_num(code[gp][2:0]);

            // R6
            num_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
                route_num[gp*NUM_W +: NUM_W] inside {4'd0, 4'd5, 4'd9, 4'd10,
                                                     4'd11, 4'd12, 4'd14, 4'd15});
        end
    endgenerate

    // R9
    route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(route_num));

    // R3
    odd_keeps_cd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_odd) |=> $stable(route_num[4*NUM_W-1:2*NUM_W]));

    // R4
    even_keeps_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !wr_odd) |=> $stable(route_num[2*NUM_W-1:0]));
endmodule

// File: rtl/rtr_line_or.sv
// Builds the interrupt vector. Each line is the OR of the asserted pins routed to it.
// Number 0 marks an unrouted pin and never drives a line.
module rtr_line_or
    import irq_rtr_pkg::*;
#(
    parameter int PINS  = PIN_CNT,
    parameter int LINES = LINE_CNT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PINS-1:0]       req,
    input  logic [PINS*NUM_W-1:0] route_num,
    output logic [LINES-1:0]      lines
);
    genvar gl;
    generate
        for (gl = 1; gl < LINES; gl++) begin : g_line
            // Gather every asserted pin whose route names this line.
            always_comb begin
                lines[gl] = 1'b0;
                for (int p = 0; p < PINS; p++)
                    if (req[p] && (route_num[p*NUM_W +: NUM_W] == NUM_W'(gl)))
                        lines[gl] = 1'b1;
            end
        end
    endgenerate

    // Line 0 is the unrouted marker and is never driven.
    always_comb lines[0] = 1'b0;

    // R8
    quiet_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> (lines == '0));

    // R8
    line_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lines) <= $countones(req));
endmodule

// File: rtl/irq_line_router.sv
// Top level of the PCI interrupt line router. It joins the byte store, the pin
// code map and the line OR stage. Requests are active high and level sensitive.
module irq_line_router
    import irq_rtr_pkg::*;
#(
    parameter logic [7:0] BASE_ADDR = 8'h88
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [7:0]  cfg_addr,
    input  logic [7:0]  cfg_wdata,
    output logic [7:0]  cfg_rdata,
    input  logic [3:0]  int_req,
    output logic [15:0] irq_out,
    output logic [15:0] route_irq
);
    logic wr_hit;
    logic wr_odd;

    rtr_cfg_store #(.ADDR_W(8), .N_BYTES(8), .BASE_ADDR(BASE_ADDR)) u_store (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .wr_hit(wr_hit), .wr_odd(wr_odd)
    );

    rtr_pin_map #(.PINS(PIN_CNT)) u_map (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_odd(wr_odd),
        .wdata(cfg_wdata), .route_num(route_irq)
    );

    rtr_line_or #(.PINS(PIN_CNT), .LINES(LINE_CNT)) u_or (
        .clk(clk), .rst_n(rst_n), .req(int_req), .route_num(route_irq),
        .lines(irq_out)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (route_irq == 16'h0000));
endmodule

// File: tb/sim_irq_line_router.sv
module sim_irq_line_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [3:0]  int_req = 4'h0;
    logic [15:0] irq_out;
    logic [15:0] route_irq;

    int total = 0;
    int bad = 0;
    logic [3:0] m_code [4];
    logic [7:0] m_mem [8];

    // 50 MHz clock
    always #10 clk = ~clk;

    irq_line_router u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .int_req(int_req),
        .irq_out(irq_out), .route_irq(route_irq)
    );

    // Vector: addr, data, requests
    localparam int NV = 11;
    localparam logic [19:0] VEC [NV] = '{
        {8'h89, 8'h21, 4'hF},   // R3 A->9 B->5
        {8'h88, 8'h43, 4'hF},   // R4 C->11 D->10
        {8'h8B, 8'h76, 4'h5},   // R10 A->15 B->14
        {8'h8A, 8'h05, 4'hA},   // R5 C off, D->12
        {8'h8D, 8'h98, 4'hF},   // R6/R7 A->5 (bit3 ignored), B off
        {8'h8C, 8'h11, 4'hC},   // R8 C,D share 5
        {8'h8F, 8'h1F, 4'hF},   // R8 A,C,D share 5, B->15
        {8'h87, 8'hFF, 4'hF},   // R9 below window
        {8'h90, 8'h33, 4'hF},   // R9 above window
        {8'h8E, 8'h80, 4'hD},   // R7 C off via 8, D off
        {8'h8E, 8'h00, 4'h0}    // R5 all even off
    };

    function automatic logic [3:0] ref_num(input logic [3:0] c);
        case (c[2:0])
            3'd1: return 4'd5;   3'd2: return 4'd9;   3'd3: return 4'd10;
            3'd4: return 4'd11;  3'd5: return 4'd12;  3'd6: return 4'd14;
            3'd7: return 4'd15;  default: return 4'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        logic [15:0] er;
        logic [15:0] eo;
        er = '0; eo = '0;
        for (int p = 0; p < 4; p++) begin
            er[p*4 +: 4] = ref_num(m_code[p]);
            if (int_req[p] && ref_num(m_code[p]) != 0) eo[ref_num(m_code[p])] = 1'b1;
        end
        check({req, " route"}, route_irq, er);
        check({req, " irq"}, irq_out, eo);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a >= 8'h88 && a <= 8'h8F) begin
            m_mem[a[2:0]] = d;
            if (a[0]) begin m_code[0] = d[7:4]; m_code[1] = d[3:0]; end
            else      begin m_code[2] = d[7:4]; m_code[3] = d[3:0]; end
        end
    endtask

    initial begin
        #1000000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_code[i] = 4'h0;
        for (int i = 0; i < 8; i++) m_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        int_req = 4'hF;
        @(negedge clk);
        // R1 reset state
        check_outputs("R1");
        for (int i = 0; i < 8; i++) begin
            cfg_addr = 8'h88 + 8'(i);
            #1 check("R1 rdata", cfg_rdata, 8'h00);
        end

        // Table walk: R3 R4 R5 R6 R7 R8 R9 R10
        for (int v = 0; v < NV; v++) begin
            do_write(VEC[v][19:12], VEC[v][11:4]);
            int_req = VEC[v][3:0];
            #1;
            check_outputs("R3/R4/R8 vector");
            if (VEC[v][19:12] >= 8'h88 && VEC[v][19:12] <= 8'h8F)
                check("R2 readback", cfg_rdata, VEC[v][11:4]);
            else
                check("R9 outside read", cfg_rdata, 8'h00);
        end

        // R2 all window bytes hold last value
        for (int i = 0; i < 8; i++) begin
            cfg_addr = 8'h88 + 8'(i);
            #1 check("R2 store", cfg_rdata, m_mem[i]);
        end

        // R8 same-cycle request response
        do_write(8'h89, 8'h11);
        do_write(8'h88, 8'h11);
        int_req = 4'h8;
        #1 check("R8 shared line", irq_out, 16'h0020);
        int_req = 4'h0;
        #1 check("R8 all idle", irq_out, 16'h0000);

        // R1 reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 4; i++) m_code[i] = 4'h0;
        int_req = 4'hF;
        cfg_addr = 8'h89;
        #1;
        check_outputs("R1 re-reset");
        check("R1 rdata after reset", cfg_rdata, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule